// File: doc/BRIEF.md
# Slow Clock Source Selector and Prescaler

This block produces the low-speed timekeeping tick of a real-time clock subsystem. Two clock-enable inputs stand in for the two possible sources. One comes from an external crystal and the other from an internal RC oscillator, both expressed as single-cycle enables in one fast system clock. A control word picks one of them. When the internal source is chosen, its enables pass through a fixed pre-divider (a build parameter) and then a programmable divider of 1 to 32. The result is a one-cycle `slow_tick`, together with `slow_tick_gated`, a copy for export that a separate gate bit controls.

Software reaches the block through a plain 32-bit register port with byte addresses. Byte address 0x00 holds the source select. A write there takes effect only when the written word carries the 16-bit unlock value 0x16AA in bits 31:16. Byte address 0x08 holds the five-bit prescale value, and byte address 0x60 holds the export gate. Changing the source or the prescale restarts the divide chain, so the first tick after a change always follows a full period.

Top module: `slck_sel`

## Requirements
- R1: After synchronous reset the internal source is selected, the prescale value is 0 and the export gate is off; reads of 0x00, 0x08 and 0x60 return 0.
- R2: A write to byte address 0x00 updates the select bit (bit 0: 1 = external, 0 = internal) only when write data bits 31:16 equal 0x16AA; any other upper value leaves the select unchanged.
- R3: A read of 0x00 returns the select in bit 0 and zero in bits 31:1; the unlock value is never stored.
- R4: Byte address 0x08 stores write data bits 4:0 as the prescale value, without any unlock value; a read returns it in bits 4:0 with zeros above.
- R5: With the external source selected, every cycle with `ext_tick_en` high yields `slow_tick` high in the following cycle, and `int_tick_en` has no effect.
- R6: With the internal source selected, `slow_tick` pulses for one cycle after every PREDIV*(prescale+1)-th `int_tick_en` pulse, and `ext_tick_en` has no effect.
- R7: An accepted write to 0x00, or any write to 0x08, clears the divide chain, and no tick results from the cycle of that write.
- R8: Byte address 0x60 bit 0 gates the export output: `slow_tick_gated` equals `slow_tick` when the gate was set in the cycle the tick was formed, and is 0 otherwise.
- R9: `reg_rdata` shows, one cycle later, the register selected by `reg_addr`; addresses that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ext_tick_en | input | 1 | Clock enable from the external crystal source |
| int_tick_en | input | 1 | Clock enable from the internal RC source |
| slow_tick | output | 1 | One-cycle tick at the selected slow rate |
| slow_tick_gated | output | 1 | Tick copy for export, enabled by the gate bit |

## Verification
The restart of the divide chain is the case that is hardest to reach from the ports, because it only shows when a prescale write lands partway through an internal period. The stimulus stops the internal enables after a random number of pulses short of a full period, rewrites the prescale with the same value, and then checks that the next tick comes a full period of enables after the write. A second directed case asserts `ext_tick_en` in the same cycle as an accepted select write and checks that no tick results from that cycle.

// File: rtl/slck_pkg.sv
package slck_pkg;
  parameter logic [15:0] UNLOCK_KEY = 16'h16AA;
  parameter int unsigned OFS_CTRL = 'h00;
  parameter int unsigned OFS_PSC  = 'h08;
  parameter int unsigned OFS_GATE = 'h60;
  parameter int unsigned PSC_W    = 5;
endpackage

// File: rtl/slck_regs.sv
module slck_regs
  import slck_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sel_ext,
  output logic [PSC_W-1:0]  psc,
  output logic              gate,
  output logic              cfg_wr
);
  logic hit_ctrl, hit_psc, hit_gate, key_ok;

  always_comb begin
    hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    hit_psc  = (reg_addr == ADDR_W'(OFS_PSC));
    hit_gate = (reg_addr == ADDR_W'(OFS_GATE));
    key_ok   = (reg_wdata[31:16] == UNLOCK_KEY);
    cfg_wr   = reg_wr && ((hit_ctrl && key_ok) || hit_psc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ext <= 1'b0;
      psc     <= '0;
      gate    <= 1'b0;
    end else if (reg_wr) begin
      if (hit_ctrl && key_ok) sel_ext <= reg_wdata[0];
      if (hit_psc)            psc     <= reg_wdata[PSC_W-1:0];
      if (hit_gate)           gate    <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (hit_ctrl)      reg_rdata[0]         <= sel_ext;
      else if (hit_psc)  reg_rdata[PSC_W-1:0] <= psc;
      else if (hit_gate) reg_rdata[0]         <= gate;
    end
  end
endmodule

// File: rtl/slck_div.sv
module slck_div
  import slck_pkg::*;
#(
  parameter int PREDIV = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             pulse
);
  logic pre_pulse;
  logic [PSC_W-1:0] cnt;

  generate
    if (PREDIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(PREDIV);
      logic [PRE_W-1:0] pre_cnt;
      assign pre_pulse = en && (pre_cnt == PRE_W'(PREDIV - 1));
      always_ff @(posedge clk) begin
        if (rst || clr)     pre_cnt <= '0;
        else if (pre_pulse) pre_cnt <= '0;
        else if (en)        pre_cnt <= pre_cnt + 1'b1;
      end
    end else begin : g_nopre
      assign pre_pulse = en;
    end
  endgenerate

  assign pulse = pre_pulse && (cnt == psc);

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt <= '0;
    else if (pulse)     cnt <= '0;
    else if (pre_pulse) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/slck_sel.sv
module slck_sel
  import slck_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PREDIV = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ext_tick_en,
  input  logic              int_tick_en,
  output logic              slow_tick,
  output logic              slow_tick_gated
);
  logic             sel_q, gate_q, cfg_wr, div_pulse, tick_nxt;
  logic [PSC_W-1:0] psc_q;

  slck_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sel_ext(sel_q), .psc(psc_q), .gate(gate_q), .cfg_wr(cfg_wr)
  );

  slck_div #(.PREDIV(PREDIV)) u_div (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(int_tick_en),
    .psc(psc_q), .pulse(div_pulse)
  );

  always_comb begin
    tick_nxt = 1'b0;
    if (!cfg_wr) tick_nxt = sel_q ? ext_tick_en : div_pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_tick       <= 1'b0;
      slow_tick_gated <= 1'b0;
    end else begin
      slow_tick       <= tick_nxt;
      slow_tick_gated <= tick_nxt && gate_q;
    end
  end
endmodule

// File: rtl/slck_sel_chk.sv
module slck_sel_chk
  import slck_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              ext_tick_en,
  input logic              int_tick_en,
  input logic              slow_tick,
  input logic              slow_tick_gated,
  input logic              sel_q,
  input logic              gate_q,
  input logic [PSC_W-1:0]  psc_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sel_q && psc_q == '0 && !gate_q && !slow_tick));

  // R2
  key_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_CTRL) && reg_wdata[31:16] != UNLOCK_KEY)
      |=> $stable(sel_q));

  // R3
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(OFS_CTRL)) |=> (reg_rdata[31:1] == '0));

  // R5
  ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q && ext_tick_en && !reg_wr) |=> slow_tick);

  // R6
  tick_source_chk: assert property (@(posedge clk) disable iff (rst)
    slow_tick |-> $past(ext_tick_en || int_tick_en));

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_q |=> !slow_tick_gated);

  // R8
  gated_sub_chk: assert property (@(posedge clk) disable iff (rst)
    slow_tick_gated |-> slow_tick);
endmodule

bind slck_sel slck_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .ext_tick_en(ext_tick_en), .int_tick_en(int_tick_en),
  .slow_tick(slow_tick), .slow_tick_gated(slow_tick_gated),
  .sel_q(sel_q), .gate_q(gate_q), .psc_q(psc_q)
);

// File: tb/slck_sel_tb.sv
module slck_sel_tb;
  localparam int AW  = 8;
  localparam int PRE = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ext_tick_en = 1'b0;
  logic          int_tick_en = 1'b0;
  logic          slow_tick, slow_tick_gated;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench-side expectation state
  bit       m_sel = 1'b0;
  bit       m_gate = 1'b0;
  int       m_psc = 0;
  int       m_cnt = 0;

  always #4 clk = ~clk;

  slck_sel #(.ADDR_W(AW), .PREDIV(PRE)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_tick_en(ext_tick_en), .int_tick_en(int_tick_en),
    .slow_tick(slow_tick), .slow_tick_gated(slow_tick_gated)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int period();
    return PRE * (m_psc + 1);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    if (a == 'h00 && d[31:16] == 16'h16AA) begin m_sel = d[0]; m_cnt = 0; end
    if (a == 'h08) begin m_psc = int'(d[4:0]); m_cnt = 0; end
    if (a == 'h60) m_gate = d[0];
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    reg_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // one cycle of enables; compare tick outputs with the expectation
  task automatic cyc(input bit e, input bit i, input string req);
    bit exp;
    exp = 1'b0;
    if (m_sel) exp = e;
    else if (i) begin
      m_cnt++;
      if (m_cnt == period()) begin exp = 1'b1; m_cnt = 0; end
    end
    ext_tick_en = e; int_tick_en = i;
    @(posedge clk); @(negedge clk);
    ext_tick_en = 1'b0; int_tick_en = 1'b0;
    check(slow_tick == exp, req, slow_tick, exp);
    check(slow_tick_gated == (exp && m_gate), "R8", slow_tick_gated, exp && m_gate);
  endtask

  task automatic run(input int n, input int dens, input string req);
    for (int k = 0; k < n; k++)
      cyc(1'($urandom % 2), ($urandom % 100) < dens, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    rd_chk('h00, 32'h0, "R1");
    rd_chk('h08, 32'h0, "R1");
    rd_chk('h60, 32'h0, "R1");
    // R9 unmapped address
    rd_chk('h04, 32'h0, "R9");
    rd_chk('h64, 32'h0, "R9");

    // R2 wrong key ignored
    wr('h00, 32'h16AB_0001);
    rd_chk('h00, 32'h0, "R2");
    wr('h00, 32'h0000_0001);
    rd_chk('h00, 32'h0, "R2");
    // R2 / R3 correct key, key not stored
    wr('h00, 32'h16AA_FFFF);
    rd_chk('h00, 32'h1, "R3");
    // R4 prescale width
    wr('h08, 32'hFFFF_FFE3);
    rd_chk('h08, 32'h3, "R4");
    wr('h08, 32'h0);
    // R8 gate register
    wr('h60, 32'h1);
    rd_chk('h60, 32'h1, "R8");

    // R5 external path, internal enables random
    run(300, 60, "R5");
    // R7 write in same cycle as an external enable: no tick
    ext_tick_en = 1'b1;
    wr('h00, 32'h16AA_0001);
    ext_tick_en = 1'b0;
    check(slow_tick == 1'b0, "R7", slow_tick, 0);

    // R6 internal, several prescale values
    wr('h00, 32'h16AA_0000);
    run(500, 70, "R6");
    wr('h60, 32'h0);
    wr('h08, 32'd3);
    run(1500, 80, "R6");
    wr('h60, 32'h1);
    wr('h08, 32'd31);
    for (int k = 0; k < 2100; k++) cyc(1'($urandom % 2), 1'b1, "R6");

    // R7 partial period then restart by rewriting the same prescale
    wr('h08, 32'd1);
    for (int k = 0; k < 40 + int'($urandom % 20); k++) cyc(1'b0, 1'b1, "R7");
    wr('h08, 32'd1);
    for (int k = 0; k < 63; k++) cyc(1'b1, 1'b1, "R7");
    int_tick_en = 1'b1;
    @(posedge clk); @(negedge clk);
    int_tick_en = 1'b0;
    check(slow_tick == 1'b1, "R7", slow_tick, 1);
    m_cnt = 0;

    // R7 source switch mid-period restarts internal chain
    for (int k = 0; k < 30; k++) cyc(1'b0, 1'b1, "R7");
    wr('h00, 32'h16AA_0001);
    wr('h00, 32'h16AA_0000);
    run(400, 90, "R7");

    // R1 reset again mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_sel = 0; m_psc = 0; m_gate = 0; m_cnt = 0;
    check(slow_tick == 1'b0, "R1", slow_tick, 0);
    rd_chk('h08, 32'h0, "R1");
    run(200, 50, "R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule